// File: doc/BRIEF.md
# Sample Interval Pacer with Channel Scanner

This block paces a data-acquisition front end. A programmable down counter advances once per 1 µs enable tick. It raises a conversion-start strobe each time its programmed interval runs out, and it reloads itself so that the next interval follows without any host action. A new programmed count takes effect at once and starts a fresh interval. Counts below 2 are raised to 2.

An asynchronous external trigger can also start a conversion. Its rising edge is synchronized and turned into a single strobe. While acquisition is enabled, both sources drive one shared strobe. In scanned mode each strobe steps a channel index through the programmed number of channels and wraps back to channel 0. In single-channel mode the index stays at channel 0. Disabling acquisition holds the interval counter at its programmed value, holds the index at 0 and blocks all strobes.

Top module: `acq_pacer`

## Requirements
- R1: After reset, `conv_start` is low and `chan_idx` is 0.
- R2: With acquisition enabled and a tick on every clock, successive `conv_start` pulses are exactly N clocks apart for a programmed count N, including the largest count the width allows.
- R3: The interval counter advances only on clocks where `tick_1us` is high, so a tick every D clocks gives pulses N·D clocks apart.
- R4: A programmed count of 0 or 1 behaves as a count of 2.
- R5: A `load_cnt` strobe reloads the counter in the same clock edge, and the first pulse after it comes exactly N ticks later.
- R6: A rising edge on `ext_conv` gives a single one-clock `conv_start` three clocks after the input changes. Holding the input high gives no further strobes.
- R7: While `acq_en` is low, `conv_start` stays low whatever the timer or `ext_conv` do.
- R8: In scanned mode (`scan_en` = 1), every `conv_start` advances `chan_idx` by one. After the strobe at index `chan_num`−1 the index returns to 0. The index does not change on clocks without a strobe.
- R9: With `scan_en` = 0, `chan_idx` is 0 on every conversion.
- R10: When `acq_en` is low, `chan_idx` is 0, so the first conversion after an enable uses channel 0.
- R11: A `chan_num` of 0 or 1 in scanned mode keeps `chan_idx` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | One-clock enable at the 1 MHz timebase rate |
| acq_en | input | 1 | Acquisition enable |
| scan_en | input | 1 | 1 = scanned mode, 0 = single channel |
| ext_conv | input | 1 | Asynchronous external conversion trigger |
| load_cnt | input | 1 | Write strobe for `cnt_val` |
| cnt_val | input | CNT_W | Sample interval in ticks |
| chan_num | input | CH_W+1 | Number of channels to scan |
| conv_start | output | 1 | Conversion-start strobe |
| chan_idx | output | CH_W | Channel used by the current conversion |

## Verification
The bench builds the block with CNT_W = 10 and CH_W = 3. The narrower counter makes the largest count, 1023, short enough to time one full interval. With CH_W = 3, `chan_num` can reach 8, so the bench can scan every index the width allows and see the wrap from the top index back to 0. The same configuration also covers the clamp at 0 and 1, the reload in the middle of an interval, the count of external strobes, and the channel reset when acquisition is enabled again.

// File: rtl/acq_pacer.sv
module acq_pacer #(
  parameter int CNT_W = 16,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1us,
  input  logic             acq_en,
  input  logic             scan_en,
  input  logic             ext_conv,
  input  logic             load_cnt,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CH_W:0]    chan_num,
  output logic             conv_start,
  output logic [CH_W-1:0]  chan_idx
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [CNT_W-1:0] reload_q, down_q;
  logic             tmr_hit_q, ext_hit_q;
  logic [2:0]       ext_sync_q;

  wire [CNT_W-1:0] cnt_clamped = (cnt_val < MIN_CNT) ? MIN_CNT : cnt_val;
  wire             at_last     = ({1'b0, chan_idx} + (CH_W+1)'(1)) >= chan_num;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q  <= MIN_CNT;
      down_q    <= MIN_CNT;
      tmr_hit_q <= 1'b0;
    end else begin
      tmr_hit_q <= 1'b0;
      if (load_cnt) begin
        reload_q <= cnt_clamped;
        down_q   <= cnt_clamped;
      end else if (!acq_en) begin
        down_q <= reload_q;
      end else if (tick_1us) begin
        if (down_q == ONE_CNT) begin
          down_q    <= reload_q;
          tmr_hit_q <= 1'b1;
        end else begin
          down_q <= down_q - ONE_CNT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync_q <= 3'b000;
      ext_hit_q  <= 1'b0;
    end else begin
      ext_sync_q <= {ext_sync_q[1:0], ext_conv};
      ext_hit_q  <= ext_sync_q[1] & ~ext_sync_q[2];
    end
  end

  assign conv_start = acq_en & (tmr_hit_q | ext_hit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 chan_idx <= '0;
    else if (!acq_en || !scan_en) chan_idx <= '0;
    else if (conv_start)        chan_idx <= at_last ? '0 : chan_idx + CH_W'(1);
  end

  assert_cnt_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (down_q != '0) && (reload_q >= MIN_CNT));
  assert_timer_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hit_q |-> (down_q == reload_q));
  assert_ext_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit_q |=> !ext_hit_q);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |-> !conv_start);
  assert_scan_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && scan_en && conv_start && at_last) |=> (chan_idx == '0));
  assert_scan_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_en && !conv_start) |=> (!acq_en || !scan_en || $stable(chan_idx)));
  assert_single_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (chan_idx == '0));
  assert_enable_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_en) |-> (chan_idx == '0));
endmodule

// File: tb/acq_pacer_tb.sv
module acq_pacer_tb;
  localparam int CNT_W = 10;
  localparam int CH_W  = 3;

  logic clk = 0, rst_n = 0, tick_1us = 0, acq_en = 0, scan_en = 0, ext_conv = 0, load_cnt = 0;
  logic [CNT_W-1:0] cnt_val = '0;
  logic [CH_W:0]    chan_num = '0;
  logic             conv_start;
  logic [CH_W-1:0]  chan_idx;
  int n_chk = 0, n_fail = 0, tick_div = 1, tcnt = 0, cyc = 0;

  acq_pacer #(.CNT_W(CNT_W), .CH_W(CH_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .acq_en(acq_en), .scan_en(scan_en),
    .ext_conv(ext_conv), .load_cnt(load_cnt), .cnt_val(cnt_val), .chan_num(chan_num),
    .conv_start(conv_start), .chan_idx(chan_idx));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt + 1 >= tick_div) begin tick_1us <= 1'b1; tcnt <= 0; end
    else begin tick_1us <= 1'b0; tcnt <= tcnt + 1; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!conv_start && n < 5000);
  endtask

  task automatic load(input int v);
    @(negedge clk); load_cnt = 1; cnt_val = CNT_W'(v);
    @(negedge clk); load_cnt = 0;
  endtask

  task automatic count_starts(input int cycles, output int s);
    s = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (conv_start) s++; end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(conv_start == 0, "R1 strobe", int'(conv_start), 0);
    chk(chan_idx == 0, "R1 channel", int'(chan_idx), 0);
  endtask

  task automatic t_period;
    int n;
    tick_div = 1; acq_en = 1;
    load(5);
    wait_start(n); chk(n == 5, "R5 first interval", n, 5);
    for (int k = 0; k < 3; k++) begin wait_start(n); chk(n == 5, "R2 period", n, 5); end
    load(1023); wait_start(n); chk(n == 1023, "R2 max count", n, 1023);
  endtask

  task automatic t_tick;
    int n;
    tick_div = 3; load(4);
    wait_start(n);
    for (int k = 0; k < 2; k++) begin wait_start(n); chk(n == 12, "R3 tick gating", n, 12); end
    tick_div = 1;
  endtask

  task automatic t_clamp;
    int n;
    load(0); wait_start(n);
    wait_start(n); chk(n == 2, "R4 count 0", n, 2);
    load(1); wait_start(n);
    wait_start(n); chk(n == 2, "R4 count 1", n, 2);
  endtask

  task automatic t_reload;
    int n;
    load(50);
    repeat (10) @(negedge clk);
    load(6); wait_start(n); chk(n == 6, "R5 reload mid-interval", n, 6);
  endtask

  task automatic t_ext;
    int n, s;
    load(1000);
    ext_conv = 1; wait_start(n); chk(n == 3, "R6 ext latency", n, 3);
    count_starts(20, s); chk(s == 0, "R6 held high", s, 0);
    ext_conv = 0; repeat (4) @(negedge clk);
    ext_conv = 1; wait_start(n); chk(n == 3, "R6 second edge", n, 3);
    ext_conv = 0; repeat (4) @(negedge clk);
  endtask

  task automatic t_idle;
    int s;
    acq_en = 0; load(3);
    ext_conv = 1; count_starts(15, s); ext_conv = 0;
    begin int s2; count_starts(15, s2); s += s2; end
    chk(s == 0, "R7 disabled", s, 0);
  endtask

  task automatic scan_run(input int num, input int starts, input string req);
    int n;
    acq_en = 0; scan_en = 1; chan_num = (CH_W+1)'(num); load(4);
    @(negedge clk); acq_en = 1;
    for (int k = 0; k < starts; k++) begin
      wait_start(n);
      chk(int'(chan_idx) == (num > 1 ? k % num : 0), req, int'(chan_idx), (num > 1 ? k % num : 0));
    end
  endtask

  task automatic t_single;
    int n;
    acq_en = 0; scan_en = 0; chan_num = 4'd5; load(4);
    @(negedge clk); acq_en = 1;
    for (int k = 0; k < 4; k++) begin
      wait_start(n); @(negedge clk);
      chk(chan_idx == 0, "R9 single channel", int'(chan_idx), 0);
    end
  endtask

  task automatic t_enable;
    int n;
    scan_run(5, 2, "R8 scan before disable");
    @(negedge clk); chk(chan_idx == 2, "R8 index advanced", int'(chan_idx), 2);
    acq_en = 0; @(negedge clk);
    chk(chan_idx == 0, "R10 disable clears", int'(chan_idx), 0);
    acq_en = 1; wait_start(n);
    chk(chan_idx == 0, "R10 first after enable", int'(chan_idx), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_period;
    t_tick;
    t_clamp;
    t_reload;
    t_ext;
    t_idle;
    scan_run(3, 7, "R8 wrap of three");
    scan_run(8, 10, "R8 wrap at full width");
    t_single;
    scan_run(1, 3, "R11 one channel");
    scan_run(0, 3, "R11 zero channels");
    t_enable;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule